// File: doc/BRIEF.md
# Serial Shift Unit Clock Selector

This block is the clocking core of a general-purpose serial port. It holds an 8-bit data shift register and a 4-bit transfer counter. It decides, cycle by cycle, which event advances each of them. There are four event sources: a software strobe written through the control port, a pulse from a timer compare match, the rising or falling edge of an external serial clock pin, and writes to a pin-toggle bit. The shift register and the counter can follow different sources. With an external clock, the counter can count both pin edges, or it can count only the software toggle writes that a master uses to drive the pin.

The external pin is brought into the system clock domain by a flop synchroniser, and its edges are turned into single-cycle events, so all state runs on one clock. The serial output comes from the top bit of the shift register. When an external clock is selected, the output passes through a latch that updates on the edge opposite the sampling edge. When an internal source is selected, the output follows the register directly. A sticky flag records each time the counter wraps.

Top module: `serShiftUnit`

## Requirements
- R1: Out of reset the data register, counter, overflow flag, pin drive value and serial output are all 0 and the source select is 00. With source 00 and no strobe written, the data register and counter hold.
- R2: A control write with source field 00 and the strobe bit 1 shifts the data register one step and adds one to the counter at the clock edge that accepts the write.
- R3: With source 01 each cycle of the timer match input shifts once and counts once. The timer input has no effect under any other source.
- R4: Source 10 shifts on rising synchronised pin edges and source 11 on falling ones. With the stored strobe bit 0, the counter advances on both edges in either case.
- R5: Under sources 10 and 11 with the stored strobe bit 1, pin edges still shift the register but no longer count. The counter advances only on control writes that carry the toggle bit set.
- R6: A control write with the toggle bit set inverts the pin drive output under every source. The drive output changes at no other time.
- R7: Under sources 1x the serial output updates from data bit 7 only on the edge opposite the shifting edge (falling for 10, rising for 11). Under sources 0x it equals data bit 7 at all times.
- R8: During a software strobe, the bit shifted in is the serial input value present one cycle before the strobe.
- R9: Shifting is MSB first: the register moves toward bit 7, the new bit enters at bit 0 and the serial output is drawn from bit 7.
- R10: A count step taken from 15 to 0 sets the overflow flag. The flag stays set until the clear input is pulsed. A wrap in the same cycle as the clear input leaves the flag set.
- R11: A change on the external pin takes effect on the third rising system clock edge after it, through a two-flop synchroniser and an edge register.
- R12: The data load and counter load inputs replace the register or counter at the next edge, taking priority over any shift or count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control write enable |
| cfgSrcSel | input | 2 | Clock source field of the control write |
| cfgStrobe | input | 1 | Strobe / counter-select bit of the control write |
| cfgToggle | input | 1 | Pin toggle bit of the control write |
| dataWe | input | 1 | Load enable for the data register |
| dataIn | input | 8 | Data register load value |
| cntWe | input | 1 | Load enable for the counter |
| cntIn | input | 4 | Counter load value |
| ovfClr | input | 1 | Clears the overflow flag |
| tmrMatch | input | 1 | Timer compare-match pulse |
| sckIn | input | 1 | External serial clock pin |
| sdi | input | 1 | Serial data input |
| dataOut | output | 8 | Data register contents |
| cntOut | output | 4 | Counter value |
| ovfFlag | output | 1 | Sticky counter overflow flag |
| sckOut | output | 1 | Driven clock pin value |
| sdo | output | 1 | Serial data output |

## Verification
The properties assume that every input is a known value from the end of reset onward. The counter-step property also assumes that a strobe write and a counter load are not issued together, so it excludes that case. The bench only changes the external pin and the serial input at falling clock edges. It holds each pin level for at least four cycles, so no two synchronised edges fall closer together than the edge detector can resolve. It also keeps the serial input steady across every external shift. Random operations are issued one at a time, with one idle cycle between them, so the source in force for each event is the one the reference model holds.

// File: rtl/serShiftPkg.sv
package serShiftPkg;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'b00,
    SRC_TIMER    = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic shiftStb;
    logic countStb;
    logic latchStb;
  } dpStrobe_t;

endpackage

// File: rtl/serShiftSync.sv
module serShiftSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic syncOut
);
  logic [STAGES-1:0] chainQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[0] <= 1'b0;
          else       chainQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[i] <= 1'b0;
          else       chainQ[i] <= chainQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];
endmodule

// File: rtl/serShiftCtrl.sv
module serShiftCtrl
  import serShiftPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic [1:0] cfgSrcSel,
  input  logic      cfgStrobe,
  input  logic      cfgToggle,
  input  logic      tmrMatch,
  input  logic      sckSync,
  input  logic      sdi,
  output dpStrobe_t stb,
  output srcSel_e   modeQ,
  output logic      sdiQ,
  output logic      sckOut
);
  logic    selQ;
  logic    sckPrevQ;
  logic    riseEv;
  logic    fallEv;
  logic    toggleWr;
  srcSel_e effMode;
  logic    effSel;
  logic    extCount;

  assign riseEv   = sckSync & ~sckPrevQ;
  assign fallEv   = ~sckSync & sckPrevQ;
  assign toggleWr = cfgWe & cfgToggle;
  assign effMode  = cfgWe ? srcSel_e'(cfgSrcSel) : modeQ;
  assign effSel   = cfgWe ? cfgStrobe : selQ;
  assign extCount = effSel ? toggleWr : (riseEv | fallEv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= SRC_NONE;
      selQ     <= 1'b0;
      sckPrevQ <= 1'b0;
      sdiQ     <= 1'b0;
      sckOut   <= 1'b0;
    end else begin
      sckPrevQ <= sckSync;
      sdiQ     <= sdi;
      if (cfgWe) begin
        modeQ <= srcSel_e'(cfgSrcSel);
        selQ  <= cfgStrobe;
      end
      if (toggleWr) sckOut <= ~sckOut;
    end
  end

  always_comb begin
    stb = '0;
    unique case (effMode)
      SRC_NONE: begin
        stb.shiftStb = cfgWe & cfgStrobe;
        stb.countStb = cfgWe & cfgStrobe;
      end
      SRC_TIMER: begin
        stb.shiftStb = tmrMatch;
        stb.countStb = tmrMatch;
      end
      SRC_EXT_RISE: begin
        stb.shiftStb = riseEv;
        stb.latchStb = fallEv;
        stb.countStb = extCount;
      end
      SRC_EXT_FALL: begin
        stb.shiftStb = fallEv;
        stb.latchStb = riseEv;
        stb.countStb = extCount;
      end
      default: stb = '0;
    endcase
  end
endmodule

// File: rtl/serShiftDp.sv
module serShiftDp
  import serShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              transparent,
  input  logic              sdiQ,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cntWe,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              ovfFlag,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] shiftQ;
  logic [CNT_W-1:0]  cntQ;
  logic              ovfQ;
  logic              latchQ;
  logic              wrapEv;

  assign wrapEv = stb.countStb & ~cntWe & (cntQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftQ <= '0;
    else if (dataWe)       shiftQ <= dataIn;
    else if (stb.shiftStb) shiftQ <= {shiftQ[DATA_W-2:0], sdiQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (cntWe)        cntQ <= cntIn;
    else if (stb.countStb) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ovfQ <= 1'b0;
    else if (wrapEv) ovfQ <= 1'b1;
    else if (ovfClr) ovfQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= 1'b0;
    else if (stb.latchStb) latchQ <= shiftQ[DATA_W-1];
  end

  assign dataOut = shiftQ;
  assign cntOut  = cntQ;
  assign ovfFlag = ovfQ;
  assign sdo     = transparent ? shiftQ[DATA_W-1] : latchQ;
endmodule

// File: rtl/serShiftUnit.sv
module serShiftUnit
  import serShiftPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSrcSel,
  input  logic              cfgStrobe,
  input  logic              cfgToggle,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cntWe,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic              ovfClr,
  input  logic              tmrMatch,
  input  logic              sckIn,
  input  logic              sdi,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              ovfFlag,
  output logic              sckOut,
  output logic              sdo
);
  dpStrobe_t stb;
  srcSel_e   modeQ;
  logic      sdiQ;
  logic      sckSync;

  serShiftSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .pinIn(sckIn), .syncOut(sckSync)
  );

  serShiftCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel),
    .cfgStrobe(cfgStrobe), .cfgToggle(cfgToggle), .tmrMatch(tmrMatch),
    .sckSync(sckSync), .sdi(sdi), .stb(stb), .modeQ(modeQ),
    .sdiQ(sdiQ), .sckOut(sckOut)
  );

  serShiftDp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .transparent(~modeQ[1]),
    .sdiQ(sdiQ), .dataWe(dataWe), .dataIn(dataIn), .cntWe(cntWe),
    .cntIn(cntIn), .ovfClr(ovfClr), .dataOut(dataOut), .cntOut(cntOut),
    .ovfFlag(ovfFlag), .sdo(sdo)
  );
endmodule

// File: rtl/serShiftChk.sv
module serShiftChk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgSrcSel,
  input logic              cfgStrobe,
  input logic              cfgToggle,
  input logic              dataWe,
  input logic              cntWe,
  input logic              ovfClr,
  input logic [1:0]        modeQ,
  input logic [DATA_W-1:0] dataOut,
  input logic [CNT_W-1:0]  cntOut,
  input logic              ovfFlag,
  input logic              sckOut,
  input logic              sdo
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b00 && !cfgWe && !dataWe && !cntWe) |=> ($stable(dataOut) && $stable(cntOut)));

  // R2
  strobe_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSrcSel == 2'b00 && cfgStrobe && !cntWe) |=> (cntOut == CNT_W'($past(cntOut) + 1'b1)));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgToggle) |=> (sckOut != $past(sckOut)));

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && cfgToggle) |=> $stable(sckOut));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R7
  transparent_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ[1] |-> (sdo == dataOut[DATA_W-1]));
endmodule

bind serShiftUnit serShiftChk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel),
  .cfgStrobe(cfgStrobe), .cfgToggle(cfgToggle), .dataWe(dataWe),
  .cntWe(cntWe), .ovfClr(ovfClr), .modeQ(modeQ), .dataOut(dataOut),
  .cntOut(cntOut), .ovfFlag(ovfFlag), .sckOut(sckOut), .sdo(sdo)
);

// File: tb/serShiftUnit_tb.sv
`timescale 1ns/1ps
module serShiftUnit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 0, cfgStrobe = 0, cfgToggle = 0;
  logic [1:0] cfgSrcSel = 0;
  logic       dataWe = 0, cntWe = 0, ovfClr = 0, tmrMatch = 0, sckIn = 0, sdi = 0;
  logic [7:0] dataIn = 0;
  logic [3:0] cntIn = 0;
  logic [7:0] dataOut;
  logic [3:0] cntOut;
  logic       ovfFlag, sckOut, sdo;

  int vecCnt = 0;
  int failCnt = 0;

  logic [7:0] mSr = 0;
  logic [3:0] mCnt = 0;
  logic       mOvf = 0, mSck = 0, mLatch = 0, mSel = 0, mSdi = 0, mPin = 0;
  logic [1:0] mMode = 0;

  always #5 clk = ~clk;

  serShiftUnit dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel),
    .cfgStrobe(cfgStrobe), .cfgToggle(cfgToggle), .dataWe(dataWe),
    .dataIn(dataIn), .cntWe(cntWe), .cntIn(cntIn), .ovfClr(ovfClr),
    .tmrMatch(tmrMatch), .sckIn(sckIn), .sdi(sdi), .dataOut(dataOut),
    .cntOut(cntOut), .ovfFlag(ovfFlag), .sckOut(sckOut), .sdo(sdo)
  );

  function automatic logic expSdo();
    return mMode[1] ? mLatch : mSr[7];
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "dataOut", dataOut, mSr);
    cmp(tag, "cntOut", cntOut, mCnt);
    cmp(tag, "ovfFlag", ovfFlag, mOvf);
    cmp(tag, "sckOut", sckOut, mSck);
    cmp(tag, "sdo", sdo, expSdo());
  endtask

  task automatic mShift(input logic b);
    mSr = {mSr[6:0], b};
  endtask

  task automatic mCount();
    if (mCnt == 4'hF) mOvf = 1'b1;
    mCnt = mCnt + 4'd1;
  endtask

  task automatic wrCfg(input logic [1:0] src, input logic stb, input logic tog);
    cfgWe = 1; cfgSrcSel = src; cfgStrobe = stb; cfgToggle = tog;
    @(negedge clk);
    cfgWe = 0; cfgStrobe = 0; cfgToggle = 0;
    mMode = src; mSel = stb;
    if (src == 2'b00 && stb) begin mShift(mSdi); mCount(); end
    if (tog) mSck = ~mSck;
    if (src[1] && stb && tog) mCount();
  endtask

  task automatic timerPulse();
    tmrMatch = 1;
    @(negedge clk);
    tmrMatch = 0;
    if (mMode == 2'b01) begin mShift(mSdi); mCount(); end
  endtask

  task automatic setSdi(input logic v);
    sdi = v;
    @(negedge clk);
    mSdi = v;
  endtask

  task automatic loadData(input logic [7:0] v);
    dataWe = 1; dataIn = v;
    @(negedge clk);
    dataWe = 0;
    mSr = v;
  endtask

  task automatic loadCnt(input logic [3:0] v);
    cntWe = 1; cntIn = v;
    @(negedge clk);
    cntWe = 0;
    mCnt = v;
  endtask

  task automatic clrOvf();
    ovfClr = 1;
    @(negedge clk);
    ovfClr = 0;
    mOvf = 0;
  endtask

  task automatic modelPin(input logic v);
    if (v != mPin) begin
      if (v) begin
        if (mMode == 2'b10) mShift(mSdi);
        if (mMode == 2'b11) mLatch = mSr[7];
      end else begin
        if (mMode == 2'b11) mShift(mSdi);
        if (mMode == 2'b10) mLatch = mSr[7];
      end
      if (mMode[1] && !mSel) mCount();
      mPin = v;
    end
  endtask

  task automatic pinTo(input logic v);
    sckIn = v;
    repeat (4) @(negedge clk);
    modelPin(v);
  endtask

  initial begin
    #2_000_000;
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");
    repeat (3) @(negedge clk);
    checkAll("R1 idle");

    // R9, R2: MSB-first strobe shifting
    loadData(8'hA5);
    checkAll("R12 load");
    setSdi(1);
    wrCfg(2'b00, 1, 0);
    checkAll("R2 strobe");
    cmp("R9 msb", "dataOut", dataOut, 8'h4B);

    // R8: bit shifted in is the previous-cycle input
    setSdi(1);
    sdi = 0; cfgWe = 1; cfgSrcSel = 2'b00; cfgStrobe = 1;
    @(negedge clk);
    cfgWe = 0; cfgStrobe = 0;
    mShift(1'b1); mCount(); mSdi = 0; mMode = 0; mSel = 1;
    checkAll("R8 prev sdi");

    // R10 overflow wrap and clear
    loadCnt(4'hF);
    wrCfg(2'b00, 1, 0);
    checkAll("R10 wrap");
    wrCfg(2'b00, 0, 0);
    checkAll("R10 sticky");
    clrOvf();
    checkAll("R10 clear");

    // R12: load wins over strobe in the same cycle
    cntWe = 1; cntIn = 4'h7; cfgWe = 1; cfgSrcSel = 2'b00; cfgStrobe = 1;
    @(negedge clk);
    cntWe = 0; cfgWe = 0; cfgStrobe = 0;
    mShift(mSdi); mCnt = 4'h7; mMode = 0; mSel = 1;
    checkAll("R12 priority");

    // R3 timer
    timerPulse();
    checkAll("R3 ignored in 00");
    wrCfg(2'b01, 0, 0);
    timerPulse();
    checkAll("R3 timer");

    // R11 synchroniser latency, R4 rising shift
    wrCfg(2'b10, 0, 0);
    loadData(8'h81);
    sckIn = 1;
    @(negedge clk); @(negedge clk);
    checkAll("R11 two edges");
    @(negedge clk);
    modelPin(1'b1);
    checkAll("R11 third edge");
    @(negedge clk);
    pinTo(0);
    checkAll("R7 latch on fall");

    // R5 strobe as select
    wrCfg(2'b11, 1, 0);
    pinTo(1);
    checkAll("R5 no count on edge");
    pinTo(0);
    checkAll("R5 shift on fall");
    wrCfg(2'b11, 1, 1);
    checkAll("R5 toggle count");

    // R6 toggle in every source
    for (int m = 0; m < 4; m++) begin
      wrCfg(m[1:0], 0, 1);
      checkAll("R6 toggle");
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: wrCfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        1: timerPulse();
        2, 3: pinTo(~mPin);
        4: setSdi(1'($urandom_range(0, 1)));
        5: loadData(8'($urandom_range(0, 255)));
        6: loadCnt(4'($urandom_range(12, 15)));
        default: clrOvf();
      endcase
      @(negedge clk);
      checkAll("R4 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule